// File: doc/BRIEF.md
# Run-time programmable 16-bit parallel CRC appender

This block computes a 16-bit cyclic redundancy check over a framed stream of 32-bit words. It accepts one word per clock. Each packet is marked by a start flag and an end flag, and a packet may be of any length. The words leave the block unchanged after a fixed latency. One extra word is then added after the last data word. That word carries the check value and becomes the new end of the packet. The check value detects corruption at the receiving end.

The update rule is not built into the logic. Each of the 16 next-state bits is the parity of one 48-bit coefficient row ANDed with the current state concatenated with the incoming word. The rows sit in a writable register bank, so software can change the polynomial by writing new rows. The data half of each row product is reduced in a registered first stage, so the recurrent state loop only carries the 16-bit state half.

A bypass control sends a whole packet through untouched, with no check word added. An error-inject control corrupts the appended word on purpose, so the receiving checker can be tested. The source must leave at least one idle input cycle after every end-of-packet word. The appended word uses that slot.

Top module: `crc_mx_gen`

## Requirements
- R1: While rst_n is low, and after reset until the first word has passed through, out_valid is 0.
- R2: A word presented with in_valid high in cycle n appears on out_data unchanged, with out_valid high, in cycle n+LAT, where LAT is a parameter (default 3). In a packet that is not bypassed, the start flag is kept and the end flag is removed from the last data word.
- R3: The cycle after the last data word of a packet that is not bypassed leaves the block, the block emits one added word. That word has out_eop=1 and out_sop=0, holds the check value in bits [15:0], and holds zero in bits [31:16].
- R4: The state is seeded with 16'hFFFF on the start word. For each valid word, next[i] is the parity of (row i AND {state, data}): row bits 47..32 pair with state bits 15..0, and row bits 31..0 pair with data bits 31..0. The added word carries the state after the end word has been processed.
- R5: After reset, the bank holds the rows that reproduce a bit-serial CRC with polynomial 16'h1021. That serial CRC takes data bit 31 first, feeds back from state bit 15, and XORs the polynomial into the state after a left shift.
- R6: A write (mx_we high) with row index mx_addr and coefficients mx_row, made while the block is idle, replaces that row. The new row is in effect for the next packet.
- R7: A write is dropped, leaving the bank unchanged, if any of these holds in that cycle: in_valid is high, a packet is open (start seen, end not yet seen), or a word still sits in the first pipeline stage.
- R8: bypass is sampled on the start word and applies to the whole packet. Such words leave unchanged after LAT cycles with their own start and end flags, and no word is added.
- R9: err_inject is sampled with the end word. When it is high, bit 0 of the added word is inverted and every other bit is unchanged.
- R10: Cycles with in_valid low inside a packet leave the state unchanged, and a packet may hold any number of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | 32 | Input data word |
| bypass | input | 1 | Pass the packet through with no check word (sampled on the start word) |
| err_inject | input | 1 | Corrupt the added word (sampled on the end word) |
| mx_we | input | 1 | Coefficient row write strobe |
| mx_addr | input | 4 | Row index (next-state bit number) |
| mx_row | input | 48 | Row coefficients: {state part, data part} |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output first word |
| out_eop | output | 1 | Output last word (the added word, or the last word when bypassed) |
| out_data | output | 32 | Output data word or check word |

## Verification
Every cycle, the assertions check the following:
- the shape of the added word (upper half zero, end flag set, start flag clear);
- that an end word in a packet that is not bypassed is always followed by an added word;
- that a write is either taken exactly as given or leaves its row untouched;
- that out_valid stays low in reset.

Only the bench scenarios can show the rest:
- the check values themselves, compared against an independent bit-serial model;
- the latency;
- the effect of a polynomial change;
- bypass and error injection;
- holes inside a packet;
- a long packet.

// File: rtl/crc_mx_pkg.sv
package crc_mx_pkg;
  parameter int CRC_W  = 16;
  parameter int DATA_W = 32;
  parameter int ROW_W  = CRC_W + DATA_W;
  parameter int ADDR_W = $clog2(CRC_W);

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ROW_W-1:0]  row_t;
  typedef row_t [CRC_W-1:0]  matrix_t;

  typedef struct packed {
    logic  valid;
    logic  is_crc;
    logic  sop;
    logic  eop;
    word_t data;
  } beat_t;

  // One word through a bit-serial LFSR, bit DATA_W-1 first.
  function automatic crc_t serial_step(crc_t c, word_t d, crc_t poly);
    crc_t r;
    logic fb;
    r = c;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return r;
  endfunction

  // Coefficient rows of the serial step, found column by column (linearity).
  function automatic matrix_t matrix_of_poly(crc_t poly);
    matrix_t m;
    row_t    unit;
    crc_t    col;
    m = '0;
    for (int j = 0; j < ROW_W; j++) begin
      unit = row_t'(1) << j;
      col  = serial_step(unit[ROW_W-1 -: CRC_W], unit[DATA_W-1:0], poly);
      for (int i = 0; i < CRC_W; i++) m[i][j] = col[i];
    end
    return m;
  endfunction

  // Parity of the state half of one row against a state value.
  function automatic logic state_term(row_t row, crc_t s);
    return ^(row[ROW_W-1 -: CRC_W] & s);
  endfunction

  // Added word: check value in the low half, optional flip of bit 0.
  function automatic word_t crc_word(crc_t c, logic flip);
    return {{(DATA_W-CRC_W){1'b0}}, c ^ {{(CRC_W-1){1'b0}}, flip}};
  endfunction
endpackage

// File: rtl/crc_mx_bank.sv
module crc_mx_bank
  import crc_mx_pkg::*;
#(
  parameter crc_t RESET_POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  row_t              wdata,
  input  logic              busy,
  output matrix_t           mat,
  output logic              wr_take,
  output logic              wr_drop
);
  localparam matrix_t RST_MAT = matrix_of_poly(RESET_POLY);

  assign wr_take = we & ~busy;
  assign wr_drop = we & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mat <= RST_MAT;
    else if (wr_take) mat[addr] <= wdata;
  end
endmodule

// File: rtl/crc_mx_front.sv
module crc_mx_front
  import crc_mx_pkg::*;
#(
  parameter int NGRP = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sop,
  input  logic                        in_eop,
  input  word_t                       in_data,
  input  logic                        bypass,
  input  logic                        err_inject,
  input  matrix_t                     mat,
  output logic                        a_valid,
  output logic                        a_sop,
  output logic                        a_eop,
  output logic                        a_byp,
  output logic                        a_err,
  output word_t                       a_data,
  output logic [CRC_W-1:0][NGRP-1:0]  a_part,
  output logic                        pkt_open
);
  localparam int GW = DATA_W / NGRP;

  logic                       byp_hold;
  logic                       eff_byp;
  logic [CRC_W-1:0][NGRP-1:0] part_d;

  assign eff_byp = in_sop ? bypass : byp_hold;

  // Data half of every row, reduced to NGRP partial parities.
  for (genvar i = 0; i < CRC_W; i++) begin : g_row
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign part_d[i][g] = ^(mat[i][g*GW +: GW] & in_data[g*GW +: GW]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid  <= 1'b0;
      a_sop    <= 1'b0;
      a_eop    <= 1'b0;
      a_byp    <= 1'b0;
      a_err    <= 1'b0;
      a_data   <= '0;
      a_part   <= '0;
      byp_hold <= 1'b0;
      pkt_open <= 1'b0;
    end else begin
      a_valid <= in_valid;
      if (in_valid) begin
        a_sop    <= in_sop;
        a_eop    <= in_eop;
        a_byp    <= eff_byp;
        a_err    <= err_inject & in_eop;
        a_data   <= in_data;
        a_part   <= part_d;
        byp_hold <= eff_byp;
        pkt_open <= ~in_eop & (in_sop | pkt_open);
      end
    end
  end
endmodule

// File: rtl/crc_mx_fold.sv
module crc_mx_fold
  import crc_mx_pkg::*;
#(
  parameter int   NGRP = 4,
  parameter crc_t SEED = 16'hFFFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       a_valid,
  input  logic                       a_sop,
  input  logic                       a_eop,
  input  logic                       a_byp,
  input  logic                       a_err,
  input  word_t                      a_data,
  input  logic [CRC_W-1:0][NGRP-1:0] a_part,
  input  matrix_t                    mat,
  output beat_t                      b_q,
  output logic                       append_req,
  output logic                       ins_crc
);
  crc_t crc_q;
  crc_t crc_next;
  crc_t base;
  logic pend_q;
  logic err_q;

  assign base = a_sop ? SEED : crc_q;

  for (genvar i = 0; i < CRC_W; i++) begin : g_next
    assign crc_next[i] = state_term(mat[i], base) ^ (^a_part[i]);
  end

  assign append_req = a_valid & a_eop & ~a_byp;
  assign ins_crc    = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      b_q    <= '0;
    end else begin
      if (a_valid && !a_byp) crc_q <= crc_next;
      pend_q <= append_req;
      err_q  <= a_err;
      if (pend_q) begin
        b_q.valid  <= 1'b1;
        b_q.is_crc <= 1'b1;
        b_q.sop    <= 1'b0;
        b_q.eop    <= 1'b1;
        b_q.data   <= crc_word(crc_q, err_q);
      end else begin
        b_q.valid  <= a_valid;
        b_q.is_crc <= 1'b0;
        b_q.sop    <= a_valid & a_sop;
        b_q.eop    <= a_valid & a_eop & a_byp;
        b_q.data   <= a_data;
      end
    end
  end
endmodule

// File: rtl/crc_mx_delay.sv
module crc_mx_delay
  import crc_mx_pkg::*;
#(
  parameter int DEPTH = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  beat_t d,
  output beat_t q
);
  if (DEPTH == 0) begin : g_none
    assign q = d;
  end else begin : g_pipe
    beat_t sr [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
      end else begin
        sr[0] <= d;
        for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
      end
    end
    assign q = sr[DEPTH-1];
  end
endmodule

// File: rtl/crc_mx_gen.sv
module crc_mx_gen
  import crc_mx_pkg::*;
#(
  parameter int   LAT        = 3,
  parameter int   NGRP       = 4,
  parameter crc_t SEED       = 16'hFFFF,
  parameter crc_t RESET_POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [31:0] in_data,
  input  logic        bypass,
  input  logic        err_inject,
  input  logic        mx_we,
  input  logic [3:0]  mx_addr,
  input  logic [47:0] mx_row,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_eop,
  output logic [31:0] out_data
);
  localparam int DEPTH = LAT - 2;

  matrix_t                    mat;
  logic                       wr_take, wr_drop, busy, pkt_open;
  logic                       a_valid, a_sop, a_eop, a_byp, a_err;
  word_t                      a_data;
  logic [CRC_W-1:0][NGRP-1:0] a_part;
  beat_t                      b_q, o_q;
  logic                       append_req, ins_crc, out_is_crc;

  assign busy = in_valid | pkt_open | a_valid;

  crc_mx_bank #(.RESET_POLY(RESET_POLY)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(mx_we), .addr(mx_addr), .wdata(mx_row),
    .busy(busy), .mat(mat), .wr_take(wr_take), .wr_drop(wr_drop)
  );

  crc_mx_front #(.NGRP(NGRP)) u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .bypass(bypass),
    .err_inject(err_inject), .mat(mat), .a_valid(a_valid), .a_sop(a_sop),
    .a_eop(a_eop), .a_byp(a_byp), .a_err(a_err), .a_data(a_data),
    .a_part(a_part), .pkt_open(pkt_open)
  );

  crc_mx_fold #(.NGRP(NGRP), .SEED(SEED)) u_fold (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_sop(a_sop),
    .a_eop(a_eop), .a_byp(a_byp), .a_err(a_err), .a_data(a_data),
    .a_part(a_part), .mat(mat), .b_q(b_q), .append_req(append_req),
    .ins_crc(ins_crc)
  );

  crc_mx_delay #(.DEPTH(DEPTH)) u_delay (
    .clk(clk), .rst_n(rst_n), .d(b_q), .q(o_q)
  );

  assign out_valid  = o_q.valid;
  assign out_sop    = o_q.sop;
  assign out_eop    = o_q.eop;
  assign out_data   = o_q.data;
  assign out_is_crc = o_q.is_crc;
endmodule

// File: rtl/crc_mx_chk.sv
module crc_mx_chk
  import crc_mx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_sop,
  input logic        out_eop,
  input logic [31:0] out_data,
  input logic        out_is_crc,
  input logic        append_req,
  input logic        ins_crc,
  input logic        wr_take,
  input logic        wr_drop,
  input logic [3:0]  mx_addr,
  input logic [47:0] mx_row,
  input matrix_t     mat
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!out_valid);
  end

  // R3
  crc_word_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_crc |-> out_valid && out_eop && !out_sop && out_data[31:16] == 16'h0);

  // R3
  append_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    append_req |=> ins_crc);

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> mat[$past(mx_addr)] == $past(mx_row));

  // R7
  write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> mat[$past(mx_addr)] == $past(mat[mx_addr]));
endmodule

bind crc_mx_gen crc_mx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sop(out_sop),
  .out_eop(out_eop), .out_data(out_data), .out_is_crc(out_is_crc),
  .append_req(append_req), .ins_crc(ins_crc), .wr_take(wr_take),
  .wr_drop(wr_drop), .mx_addr(mx_addr), .mx_row(mx_row), .mat(mat)
);

// File: tb/tb_crc_mx_gen.sv
module tb_crc_mx_gen;
  localparam int LAT = 3;

  typedef struct {
    logic [31:0] data;
    logic        sop;
    logic        eop;
    int          due;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic        bypass = 1'b0, err_inject = 1'b0, mx_we = 1'b0;
  logic [3:0]  mx_addr = '0;
  logic [47:0] mx_row = '0;
  logic        out_valid, out_sop, out_eop;
  logic [31:0] out_data;

  int    cyc = 0, n_tests = 0, n_fail = 0;
  bit    finished = 0;
  exp_t  q[$];
  logic [15:0] m_poly = 16'h1021;
  logic [15:0] m_crc = '0;
  bit          m_byp = 0;

  crc_mx_gen #(.LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .bypass(bypass),
    .err_inject(err_inject), .mx_we(mx_we), .mx_addr(mx_addr),
    .mx_row(mx_row), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Independent model: shift-register CRC over the word, msb first.
  function automatic logic [15:0] ref_crc(logic [15:0] s, logic [31:0] w, logic [15:0] p);
    logic [15:0] r;
    r = s;
    for (int n = 0; n < 32; n++) begin
      if (r[15] ^ w[31-n]) r = (r << 1) ^ p;
      else                 r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [47:0] ref_row(logic [15:0] p, int i);
    logic [47:0] row, v;
    logic [15:0] res;
    for (int j = 0; j < 48; j++) begin
      v      = 48'd1 << j;
      res    = ref_crc(v[47:32], v[31:0], p);
      row[j] = res[i];
    end
    return row;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  // Monitor: scoreboard compare at the negative edge.
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].due < cyc) begin
        check(0, q[0].tag, "missing word", 0, q[0].data);
        void'(q.pop_front());
      end
      if (out_valid) begin
        if (q.size() == 0 || q[0].due != cyc) begin
          check(0, "R2", "unexpected word", out_data, 0);
        end else begin
          check(out_data == q[0].data && out_sop == q[0].sop && out_eop == q[0].eop,
                q[0].tag, "word/flags",
                {out_sop, out_eop, out_data}, {q[0].sop, q[0].eop, q[0].data});
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic send(input logic [31:0] d, input bit sop, input bit eop,
                      input bit byp, input bit err, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1; in_data = d; in_sop = sop; in_eop = eop;
    bypass = byp; err_inject = err;
    if (sop) begin m_byp = byp; m_crc = 16'hFFFF; end
    if (!m_byp) m_crc = ref_crc(m_crc, d, m_poly);
    e.data = d; e.sop = sop; e.eop = m_byp ? eop : 1'b0;
    e.due = cyc + LAT; e.tag = m_byp ? "R8" : "R2";
    q.push_back(e);
    if (eop && !m_byp) begin
      e.data = {16'h0, m_crc ^ {15'h0, err}};
      e.sop = 0; e.eop = 1; e.due = cyc + LAT + 1; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_eop = 0; bypass = 0; err_inject = 0; mx_we = 0;
    end
  endtask

  task automatic packet(input int len, input logic [31:0] base, input bit byp,
                        input bit err, input string tag);
    for (int k = 0; k < len; k++)
      send(base ^ (32'h9E3779B9 * k), k == 0, k == len - 1, byp, err, tag);
    idle(1);
  endtask

  task automatic load_poly(input logic [15:0] p);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      in_valid = 0; mx_we = 1; mx_addr = 4'(i); mx_row = ref_row(p, i);
    end
    @(negedge clk);
    mx_we = 0;
    m_poly = p;
  endtask

  initial begin
    #1 rst_n = 0;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    end
    rst_n = 1;
    repeat (2) begin
      @(negedge clk);
      check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    end

    // R5: default rows, four-word packet; R2/R3/R4 on every word
    packet(4, 32'h0123_4567, 0, 0, "R5");
    idle(2);
    // single-word packet (start and end together), R4
    packet(1, 32'hDEAD_BEEF, 0, 0, "R4");
    // back-to-back packets with the single required gap, R3
    packet(3, 32'hA5A5_0000, 0, 0, "R3");
    packet(2, 32'h0000_FFFF, 0, 0, "R3");
    idle(4);

    // R6: new polynomial written while idle
    load_poly(16'h8005);
    packet(5, 32'h1357_9BDF, 0, 0, "R6");
    idle(4);

    // R7: writes during an open packet are dropped
    send(32'h1111_2222, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      in_valid = 0; mx_we = 1; mx_addr = 4'(i); mx_row = ref_row(16'h1021, i);
    end
    @(negedge clk); mx_we = 0;
    send(32'h3333_4444, 0, 0, 0, 0, "R7");
    send(32'h5555_6666, 0, 1, 0, 0, "R7");
    idle(4);
    // R7: writes in the same cycle as a word, and while it sits in stage one
    send(32'h7777_8888, 1, 1, 0, 0, "R7");
    mx_we = 1; mx_addr = 4'd3; mx_row = 48'hFFFF_FFFF_FFFF;
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    mx_addr = 4'd5;
    idle(4);
    packet(3, 32'h2468_ACE0, 0, 0, "R7");
    idle(4);

    // R8: bypassed packet, then a normal one
    packet(4, 32'hCAFE_F00D, 1, 0, "R8");
    packet(2, 32'hBEEF_0001, 0, 0, "R8");
    idle(3);

    // R9: error inject flips bit 0 of the added word only
    packet(3, 32'h0F0F_F0F0, 0, 1, "R9");
    idle(3);

    // R10: holes inside a packet, then a long packet
    load_poly(16'h1021);
    send(32'hAAAA_5555, 1, 0, 0, 0, "R10");
    idle(3);
    send(32'h5555_AAAA, 0, 0, 0, 0, "R10");
    idle(2);
    send(32'h0000_0001, 0, 1, 0, 0, "R10");
    idle(3);
    packet(300, 32'h7A5C_3E19, 0, 0, "R10");
    idle(10);

    check(q.size() == 0, "R2", "words left unmatched", q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule